// File: doc/BRIEF.md
# Camera exposure and readout sequencer

This block sequences a still-image capture inside an image-sensor timing generator. Software stages its settings and a trigger through a small write port. The settings are a field count for exposure, a field count for readout, line positions for the strobe, the shutter close and the bias turn-on, and a bias mode. Nothing staged acts until the next falling edge of vertical sync. At that edge a pending trigger launches a chain that needs no further writes: exposure fields, then readout fields, then a return to idle.

During exposure the block gates off the transfer-gate pulses. If enabled, it also gates off the substrate-clear pulses, and it keeps them off through readout. While exposure runs, it compares the incoming line counter against the programmed positions on each falling edge of horizontal sync. Those matches drive the strobe on and off, close the mechanical shutter and turn on the substrate bias. The current phase is reported on a two-bit indicator. When the chain ends, clearing resumes, transfer timing returns to normal, the shutter reopens and the bias drops.

Top module: `cam_expo_seq`

## Requirements
- R1: After reset the block is idle: field_phase is 0, subclr_en and xfer_en are 1, strobe and bias are 0, shutter_open is 1.
- R2: Writes are staged. A written trigger, count or line position has no effect until the next vsync falling edge. The register addresses are 0 trigger, 1 exposure count, 2 readout count, 3 bias mode (bit 0), 4 shutter-reopen command, 5 bias-on line, 6 shutter-close line, 7 strobe-on line and 8 strobe-off line.
- R3: field_phase is encoded as 0 idle, 1 exposure and 2 readout. Trigger bit 0 starts a sequence at the next vsync falling edge, and field_phase changes only on such an edge.
- R4: Exposure lasts the exposure count plus one fields. With a count of 0, readout starts at the next vsync falling edge. xfer_en is 0 only while in exposure.
- R5: Readout lasts exactly the readout count in fields. A readout count of 0 returns to idle directly from exposure.
- R6: With trigger bit 4 set, subclr_en is 0 throughout exposure and readout. With bit 4 clear, subclr_en stays 1.
- R7: With trigger bit 1 set, strobe rises on an hsync falling edge whose line matches the strobe-on line during exposure. It falls at the strobe-off line, and when both lines are equal the strobe stays off.
- R8: With trigger bit 2 set, shutter_open falls at the shutter-close line during exposure. It stays low through readout and reopens at sequence end, or at the vsync falling edge after a write to the reopen command.
- R9: With trigger bit 3 set and bias mode 0, bias rises at the bias-on line during exposure. With bias mode 1 it rises on the starting vsync edge. It returns to 0 when the sequence ends.
- R10: An output whose trigger enable bit is clear keeps its idle level for the whole sequence.
- R11: A trigger starts one sequence and is then consumed. A trigger written while a sequence runs is dropped and does not change that sequence's enables.
- R12: On the vsync edge that ends exposure, the strobe is forced off even if a strobe-on line matches in that cycle. A shutter-close line match in that same cycle still closes the shutter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| vsync | input | 1 | Vertical sync; its falling edge is a field boundary |
| hsync | input | 1 | Horizontal sync; its falling edge samples line_cnt |
| line_cnt | input | LINE_W | Current line number |
| subclr_en | output | 1 | Substrate-clear pulses allowed |
| xfer_en | output | 1 | Transfer-gate pulses allowed with normal timing |
| strobe | output | 1 | Flash strobe level |
| shutter_open | output | 1 | Mechanical shutter open level |
| bias | output | 1 | Substrate-bias active level |
| field_phase | output | 2 | 0 idle, 1 exposure, 2 readout |

## Verification
Two events can land in the same clock cycle: the vsync falling edge that closes exposure, and an hsync falling edge whose line matches a programmed position. The bench forces both by dropping vsync and hsync together with line_cnt set to the strobe-on line, and then to the shutter-close line. It then checks that field_phase has moved to readout, that the strobe stayed low, and that the shutter closed anyway. A related case, where the strobe-on and strobe-off lines are equal, checks that the off action wins when both apply on one edge.

// File: rtl/cam_seq_pkg.sv
package cam_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_EXPOSE = 2'd1,
    PH_READ   = 2'd2
  } phase_t;

  // register addresses
  localparam int ADDR_TRIG    = 0;
  localparam int ADDR_EXPO    = 1;
  localparam int ADDR_RDOUT   = 2;
  localparam int ADDR_BMODE   = 3;
  localparam int ADDR_SHUT_ON = 4;
  localparam int ADDR_LINE0   = 5;

  // line-position registers, indexed from ADDR_LINE0
  localparam int N_LINE      = 4;
  localparam int LN_BIAS_ON  = 0;
  localparam int LN_SHUT_OFF = 1;
  localparam int LN_STRB_ON  = 2;
  localparam int LN_STRB_OFF = 3;

  // trigger bits
  localparam int TRIG_W   = 5;
  localparam int TB_START = 0;
  localparam int TB_BIAS  = 3;

  // latched enables = trigger[4:1]
  localparam int EN_W    = TRIG_W - 1;
  localparam int EN_STRB = 0;
  localparam int EN_SHUT = 1;
  localparam int EN_BIAS = 2;
  localparam int EN_SUP  = 3;

endpackage

// File: rtl/cam_seq_regs.sv
module cam_seq_regs
  import cam_seq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 12,
  parameter int LINE_W = 12,
  parameter int CNT_W  = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic                           vd_fall,
  output logic [TRIG_W-1:0]              trig_pend,
  output logic [CNT_W-1:0]               expo_sh,
  output logic [CNT_W-1:0]               rdout_act,
  output logic                           bmode_sh,
  output logic                           bmode_act,
  output logic [N_LINE-1:0][LINE_W-1:0]  line_act,
  output logic                           open_cmd
);

  logic [TRIG_W-1:0] trig_q, trig_d;
  logic [CNT_W-1:0]  expo_q, expo_d;
  logic [CNT_W-1:0]  rd_sh_q, rd_sh_d, rd_act_q, rd_act_d;
  logic              bm_sh_q, bm_sh_d, bm_act_q, bm_act_d;
  logic              shon_q, shon_d;

  always_comb begin
    trig_d   = trig_q;
    expo_d   = expo_q;
    rd_sh_d  = rd_sh_q;
    bm_sh_d  = bm_sh_q;
    shon_d   = shon_q;
    // pending one-shot items are consumed at every field boundary
    if (vd_fall) begin
      trig_d = '0;
      shon_d = 1'b0;
    end
    if (wr_en) begin
      case (int'(wr_addr))
        ADDR_TRIG:    trig_d  = wr_data[TRIG_W-1:0];
        ADDR_EXPO:    expo_d  = wr_data[CNT_W-1:0];
        ADDR_RDOUT:   rd_sh_d = wr_data[CNT_W-1:0];
        ADDR_BMODE:   bm_sh_d = wr_data[0];
        ADDR_SHUT_ON: shon_d  = 1'b1;
        default:      ;
      endcase
    end
    rd_act_d = vd_fall ? rd_sh_q : rd_act_q;
    bm_act_d = vd_fall ? bm_sh_q : bm_act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q   <= '0;
      expo_q   <= '0;
      rd_sh_q  <= '0;
      rd_act_q <= '0;
      bm_sh_q  <= 1'b0;
      bm_act_q <= 1'b0;
      shon_q   <= 1'b0;
    end else begin
      trig_q   <= trig_d;
      expo_q   <= expo_d;
      rd_sh_q  <= rd_sh_d;
      rd_act_q <= rd_act_d;
      bm_sh_q  <= bm_sh_d;
      bm_act_q <= bm_act_d;
      shon_q   <= shon_d;
    end
  end

  for (genvar g = 0; g < N_LINE; g++) begin : g_line
    logic [LINE_W-1:0] sh_q, sh_d, act_q, act_d;

    always_comb begin
      sh_d = sh_q;
      if (wr_en && (int'(wr_addr) == ADDR_LINE0 + g))
        sh_d = wr_data[LINE_W-1:0];
      act_d = vd_fall ? sh_q : act_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q  <= '0;
        act_q <= '0;
      end else begin
        sh_q  <= sh_d;
        act_q <= act_d;
      end
    end

    assign line_act[g] = act_q;
  end

  assign trig_pend = trig_q;
  assign expo_sh   = expo_q;
  assign rdout_act = rd_act_q;
  assign bmode_sh  = bm_sh_q;
  assign bmode_act = bm_act_q;
  assign open_cmd  = vd_fall & shon_q;

  // R2: active line positions move only on a field boundary
  assert_line_staged_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !vd_fall |=> $stable(line_act));

endmodule

// File: rtl/cam_seq_fsm.sv
module cam_seq_fsm
  import cam_seq_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vd_fall,
  input  logic [TRIG_W-1:0] trig_pend,
  input  logic [CNT_W-1:0]  expo_sh,
  input  logic [CNT_W-1:0]  rdout_act,
  output phase_t            phase,
  output logic [EN_W-1:0]   en,
  output logic              start,
  output logic              exp_end,
  output logic              done
);

  phase_t            ph_q, ph_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [EN_W-1:0]   en_q, en_d;

  always_comb begin
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    en_d    = en_q;
    start   = 1'b0;
    exp_end = 1'b0;
    done    = 1'b0;
    if (vd_fall) begin
      case (ph_q)
        PH_IDLE: begin
          if (trig_pend[TB_START]) begin
            ph_d  = PH_EXPOSE;
            cnt_d = expo_sh;
            en_d  = trig_pend[TRIG_W-1:1];
            start = 1'b1;
          end
        end
        PH_EXPOSE: begin
          if (cnt_q == '0) begin
            exp_end = 1'b1;
            if (rdout_act == '0) begin
              ph_d = PH_IDLE;
              done = 1'b1;
            end else begin
              ph_d  = PH_READ;
              cnt_d = rdout_act - 1'b1;
            end
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        PH_READ: begin
          if (cnt_q == '0) begin
            ph_d = PH_IDLE;
            done = 1'b1;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      en_q  <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      en_q  <= en_d;
    end
  end

  assign phase = ph_q;
  assign en    = en_q;

  // R3: phase advances only at a field boundary
  assert_phase_on_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !vd_fall |=> $stable(ph_q));

  // R11: a running sequence keeps the enables it started with
  assert_trig_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (vd_fall && ph_q != PH_IDLE) |=> $stable(en_q));

endmodule

// File: rtl/cam_seq_out.sv
module cam_seq_out
  import cam_seq_pkg::*;
#(
  parameter int LINE_W = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          hd_fall,
  input  logic [LINE_W-1:0]             line_cnt,
  input  logic [N_LINE-1:0][LINE_W-1:0] line_act,
  input  phase_t                        phase,
  input  logic [EN_W-2:0]               en_out,
  input  logic                          start,
  input  logic                          trig_bias,
  input  logic                          bmode_sh,
  input  logic                          bmode_act,
  input  logic                          exp_end,
  input  logic                          done,
  input  logic                          open_cmd,
  output logic                          strobe,
  output logic                          shutter_open,
  output logic                          bias
);

  logic [N_LINE-1:0] hit;
  logic in_exp;
  logic strb_q, strb_d, closed_q, closed_d, bias_q, bias_d;

  for (genvar g = 0; g < N_LINE; g++) begin : g_hit
    assign hit[g] = hd_fall && (line_cnt == line_act[g]);
  end

  assign in_exp = (phase == PH_EXPOSE);

  always_comb begin
    strb_d = strb_q;
    if (in_exp && en_out[EN_STRB]) begin
      if (hit[LN_STRB_ON])  strb_d = 1'b1;
      if (hit[LN_STRB_OFF]) strb_d = 1'b0;
    end
    if (exp_end || done) strb_d = 1'b0;

    closed_d = closed_q;
    if (in_exp && en_out[EN_SHUT] && hit[LN_SHUT_OFF]) closed_d = 1'b1;
    if (done || open_cmd) closed_d = 1'b0;

    bias_d = bias_q;
    if (in_exp && en_out[EN_BIAS] && !bmode_act && hit[LN_BIAS_ON]) bias_d = 1'b1;
    if (start && trig_bias && bmode_sh) bias_d = 1'b1;
    if (done) bias_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q   <= 1'b0;
      closed_q <= 1'b0;
      bias_q   <= 1'b0;
    end else begin
      strb_q   <= strb_d;
      closed_q <= closed_d;
      bias_q   <= bias_d;
    end
  end

  assign strobe       = strb_q;
  assign shutter_open = ~closed_q;
  assign bias         = bias_q;

  // R7: the strobe only lights inside exposure
  assert_strobe_in_exp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strb_q) |-> (phase == PH_EXPOSE));

  // R8: the shutter only closes inside a running sequence
  assert_shutter_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shutter_open) |-> (phase != PH_IDLE));

  // R9: bias is never active while idle
  assert_bias_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !bias_q);

endmodule

// File: rtl/cam_expo_seq.sv
module cam_expo_seq
  import cam_seq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 12,
  parameter int LINE_W = 12,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              vsync,
  input  logic              hsync,
  input  logic [LINE_W-1:0] line_cnt,
  output logic              subclr_en,
  output logic              xfer_en,
  output logic              strobe,
  output logic              shutter_open,
  output logic              bias,
  output logic [1:0]        field_phase
);

  logic [1:0] rst_sync;
  logic       rst_sn;
  logic       vs_q, hs_q, vd_fall, hd_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sn = rst_sync[1];

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      vs_q <= 1'b0;
      hs_q <= 1'b0;
    end else begin
      vs_q <= vsync;
      hs_q <= hsync;
    end
  end
  assign vd_fall = vs_q & ~vsync;
  assign hd_fall = hs_q & ~hsync;

  logic [TRIG_W-1:0]             trig_pend;
  logic [CNT_W-1:0]              expo_sh, rdout_act;
  logic                          bmode_sh, bmode_act, open_cmd;
  logic [N_LINE-1:0][LINE_W-1:0] line_act;
  phase_t                        phase;
  logic [EN_W-1:0]               en;
  logic                          start, exp_end, done;

  cam_seq_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_W(LINE_W), .CNT_W(CNT_W)
  ) i_regs (
    .clk(clk), .rst_n(rst_sn), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vd_fall(vd_fall), .trig_pend(trig_pend), .expo_sh(expo_sh), .rdout_act(rdout_act),
    .bmode_sh(bmode_sh), .bmode_act(bmode_act), .line_act(line_act), .open_cmd(open_cmd)
  );

  cam_seq_fsm #(.CNT_W(CNT_W)) i_fsm (
    .clk(clk), .rst_n(rst_sn), .vd_fall(vd_fall), .trig_pend(trig_pend),
    .expo_sh(expo_sh), .rdout_act(rdout_act), .phase(phase), .en(en),
    .start(start), .exp_end(exp_end), .done(done)
  );

  cam_seq_out #(.LINE_W(LINE_W)) i_out (
    .clk(clk), .rst_n(rst_sn), .hd_fall(hd_fall), .line_cnt(line_cnt),
    .line_act(line_act), .phase(phase), .en_out(en[EN_W-2:0]), .start(start),
    .trig_bias(trig_pend[TB_BIAS]), .bmode_sh(bmode_sh), .bmode_act(bmode_act),
    .exp_end(exp_end), .done(done), .open_cmd(open_cmd),
    .strobe(strobe), .shutter_open(shutter_open), .bias(bias)
  );

  assign subclr_en   = !(en[EN_SUP] && (phase != PH_IDLE));
  assign xfer_en     = (phase != PH_EXPOSE);
  assign field_phase = phase;

  // R8: back in idle the shutter is always open
  assert_open_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    (phase == PH_IDLE) |-> shutter_open);

endmodule

// File: tb/test_cam_expo_seq.sv
`timescale 1ns/1ps
module test_cam_expo_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [11:0] wr_data;
  logic        vsync, hsync;
  logic [11:0] line_cnt;
  logic        subclr_en, xfer_en, strobe, shutter_open, bias;
  logic [1:0]  field_phase;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  cam_expo_seq i_cam_expo_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vsync(vsync), .hsync(hsync), .line_cnt(line_cnt),
    .subclr_en(subclr_en), .xfer_en(xfer_en), .strobe(strobe),
    .shutter_open(shutter_open), .bias(bias), .field_phase(field_phase)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(addr); wr_data = 12'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic vd();
    @(negedge clk); vsync = 1'b1;
    @(negedge clk); vsync = 1'b0;
    @(negedge clk);
  endtask

  task automatic hd(input int line);
    @(negedge clk); line_cnt = 12'(line); hsync = 1'b1;
    @(negedge clk); hsync = 1'b0;
    @(negedge clk);
  endtask

  task automatic vd_hd(input int line);
    @(negedge clk); line_cnt = 12'(line); hsync = 1'b1; vsync = 1'b1;
    @(negedge clk); hsync = 1'b0; vsync = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1", "phase", field_phase, 0);
    check("R1", "subclr_en", subclr_en, 1);
    check("R1", "xfer_en", xfer_en, 1);
    check("R1", "strobe", strobe, 0);
    check("R1", "shutter_open", shutter_open, 1);
    check("R1", "bias", bias, 0);
  endtask

  task automatic t_full();
    wr(1, 1); wr(2, 3); wr(3, 0);
    wr(5, 3); wr(6, 9); wr(7, 5); wr(8, 7);
    wr(0, 31);
    hd(3);
    check("R2", "phase before sync", field_phase, 0);
    check("R2", "bias before sync", bias, 0);
    vd();
    check("R3", "phase exposure", field_phase, 1);
    check("R6", "subclr suppressed", subclr_en, 0);
    check("R4", "xfer off in exposure", xfer_en, 0);
    hd(3);
    check("R9", "bias at line", bias, 1);
    hd(5);
    check("R7", "strobe on", strobe, 1);
    hd(7);
    check("R7", "strobe off", strobe, 0);
    wr(7, 11);
    hd(11);
    check("R2", "staged strobe line unused", strobe, 0);
    hd(9);
    check("R8", "shutter closed", shutter_open, 0);
    vd();
    check("R4", "second exposure field", field_phase, 1);
    vd();
    check("R4", "readout after expo+1", field_phase, 2);
    check("R4", "xfer back in readout", xfer_en, 1);
    check("R6", "subclr held in readout", subclr_en, 0);
    check("R8", "shutter closed in readout", shutter_open, 0);
    check("R9", "bias held in readout", bias, 1);
    vd();
    check("R5", "readout field 2", field_phase, 2);
    vd();
    check("R5", "readout field 3", field_phase, 2);
    vd();
    check("R5", "idle after 3 fields", field_phase, 0);
    check("R6", "subclr resumes", subclr_en, 1);
    check("R8", "shutter reopens", shutter_open, 1);
    check("R9", "bias drops", bias, 0);
    vd();
    check("R11", "trigger consumed", field_phase, 0);
  endtask

  task automatic t_disabled_zero();
    wr(1, 0); wr(2, 0); wr(0, 1);
    vd();
    check("R4", "expo 0 enters exposure", field_phase, 1);
    check("R6", "no suppression without bit4", subclr_en, 1);
    hd(11); hd(7);
    check("R10", "strobe disabled", strobe, 0);
    hd(9);
    check("R10", "shutter disabled", shutter_open, 1);
    hd(3);
    check("R10", "bias disabled", bias, 0);
    vd();
    check("R5", "readout 0 goes idle", field_phase, 0);
  endtask

  task automatic t_retrigger();
    wr(1, 0); wr(2, 2); wr(0, 1);
    vd();
    check("R11", "started", field_phase, 1);
    wr(0, 31);
    vd();
    check("R11", "readout field 1", field_phase, 2);
    check("R11", "enables unchanged", subclr_en, 1);
    vd();
    check("R5", "readout field 2", field_phase, 2);
    vd();
    check("R5", "idle after 2", field_phase, 0);
    vd();
    check("R11", "late trigger dropped", field_phase, 0);
  endtask

  task automatic t_bias_mode1();
    wr(3, 1); wr(1, 0); wr(2, 1); wr(0, 13);
    vd();
    check("R9", "bias on at start edge", bias, 1);
    hd(9);
    check("R8", "shutter closed", shutter_open, 0);
    wr(4, 1);
    vd();
    check("R8", "reopen command", shutter_open, 1);
    check("R5", "readout", field_phase, 2);
    vd();
    check("R9", "bias off at end", bias, 0);
    wr(3, 0);
  endtask

  task automatic t_collide();
    wr(7, 5); wr(8, 7); wr(1, 0); wr(2, 1); wr(0, 7);
    vd();
    vd_hd(5);
    check("R12", "phase moved", field_phase, 2);
    check("R12", "strobe forced off", strobe, 0);
    vd();
    wr(0, 7);
    vd();
    vd_hd(9);
    check("R12", "phase moved", field_phase, 2);
    check("R12", "shutter closes on edge", shutter_open, 0);
    vd();
    check("R8", "reopen at end", shutter_open, 1);
    wr(7, 4); wr(8, 4); wr(2, 0); wr(0, 3);
    vd();
    hd(4);
    check("R7", "equal lines keep off", strobe, 0);
    vd();
    check("R5", "idle", field_phase, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog: run did not finish");
    n_err++;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    vsync = 1'b0; hsync = 1'b0; line_cnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_full();
    t_disabled_zero();
    t_retrigger();
    t_bias_mode1();
    t_collide();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule